// File: doc/BRIEF.md
# SDRAM Open-Row Policy Sequencer

This block sits between a request source and a four-bank SDRAM command bus. It remembers which row is open in each bank. It sorts each accepted access into one of three classes: a hit on the open row, a miss against a different open row, or a bank with nothing open. It then emits the matching series of precharge, activate and column commands.

A policy input chooses how a miss is resolved. In one setting only the conflicting bank is closed, and the rows open in the other banks stay available for later hits. In the other setting one close-everything command clears every bank at once. The precharge-to-activate gap and the activate-to-column gap come from programmable inputs. A read-data-due strobe marks the first-data time after each read, at a leadoff of 3 or 4 cycles. Per-bank event counters expose the classification of every access.

Top module: `pgpol_ctrl`

## Requirements
- R1: After reset, `req_ready` is 1, `cmd_valid` and `rd_due` are 0, every counter is zero, and no bank holds an open row, so the first access to any bank is classed as empty.
- R2: An access whose row equals the open row of its bank produces exactly one command: READ (`cmd_op`=4) or WRITE (`cmd_op`=5), with the request's bank and column, in the cycle after acceptance. No precharge or activate is issued.
- R3: An access to a bank with no open row produces ACTIVATE (`cmd_op`=1) with the requested bank and row in the cycle after acceptance. The column command follows `t_rcd` cycles later, and a value of 0 acts as 1. No precharge is issued.
- R4: With `close_all`=0 at acceptance, a miss issues PRECHARGE (`cmd_op`=2) to that bank alone in the cycle after acceptance. ACTIVATE follows `t_rp` cycles later (0 acts as 1), and then the column command `t_rcd` cycles after that. Rows open in other banks stay open and still hit afterwards.
- R5: With `close_all`=1 at acceptance, a miss issues PRECHARGE-ALL (`cmd_op`=3). Every bank closes in the same cycle, so a later access to any other bank is classed as empty and needs only ACTIVATE.
- R6: `req_ready` goes low in the cycle after acceptance. It stays low until the column command has been issued, and it returns high in the cycle after that command.
- R7: `rd_due` pulses for one cycle 4 cycles after a READ command when `fast_leadoff` was 0 in the READ cycle, and 3 cycles after it when `fast_leadoff` was 1. A WRITE raises no pulse.
- R8: Bank b's counts sit at bits [b*CNT_W +: CNT_W] of `hit_cnt`, `miss_cnt` and `empty_cnt`. Each accepted access adds one to exactly one of them, for its bank and its class.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_bank | input | BANK_W | Request bank |
| req_row | input | ROW_W | Request row |
| req_col | input | COL_W | Request column |
| req_write | input | 1 | 1 = write, 0 = read |
| close_all | input | 1 | Miss policy: 1 closes all banks, 0 closes the missed bank |
| fast_leadoff | input | 1 | 1 = 3-cycle read leadoff, 0 = 4-cycle |
| t_rp | input | GAP_W | Cycles from precharge to activate |
| t_rcd | input | GAP_W | Cycles from activate to column command |
| cmd_valid | output | 1 | A command is on the bus this cycle |
| cmd_op | output | 3 | 1 ACT, 2 PRE, 3 PRE-ALL, 4 READ, 5 WRITE |
| cmd_bank | output | BANK_W | Command bank |
| cmd_row | output | ROW_W | Row for ACTIVATE |
| cmd_col | output | COL_W | Column for READ/WRITE |
| rd_due | output | 1 | First read data expected this cycle |
| hit_cnt | output | NBANK*CNT_W | Per-bank hit counts |
| miss_cnt | output | NBANK*CNT_W | Per-bank miss counts |
| empty_cnt | output | NBANK*CNT_W | Per-bank empty-bank counts |

## Verification
A wrong entry in the open-row table shows at the ports on the next access to that bank. A stale valid flag turns an empty access into a spurious PRECHARGE in the cycle after acceptance. A cleared flag turns a hit into an extra ACTIVATE, and a wrong stored row changes hit into miss or the reverse. Each of these also moves the wrong event counter one cycle after acceptance. A fault in the gap or leadoff timing moves the column command or the `rd_due` pulse by whole cycles, which a per-cycle command log relative to acceptance exposes directly.

// File: rtl/pgpol_pkg.sv
package pgpol_pkg;

  typedef enum logic [2:0] {
    OP_NOP  = 3'd0,
    OP_ACT  = 3'd1,
    OP_PRE  = 3'd2,
    OP_PREA = 3'd3,
    OP_RD   = 3'd4,
    OP_WR   = 3'd5
  } op_e;

  typedef enum logic [1:0] {
    K_HIT   = 2'd0,
    K_MISS  = 2'd1,
    K_EMPTY = 2'd2
  } kind_e;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_PRE  = 2'd1,
    S_ACT  = 2'd2,
    S_RW   = 2'd3
  } st_e;

  localparam int LEAD_MAX = 4;

  // read leadoff in cycles for the selected speed
  function automatic int unsigned lead_cycles(input logic fast);
    return fast ? 32'd3 : 32'd4;
  endfunction

  // timer preload so that the next command lands t cycles later (0 acts as 1)
  function automatic int unsigned gap_preload(input int unsigned t);
    return (t == 0) ? 32'd0 : t - 32'd1;
  endfunction

endpackage

// File: rtl/pgpol_bank_table.sv
module pgpol_bank_table
  import pgpol_pkg::*;
#(
  parameter int NBANK = 4,
  parameter int ROW_W = 13,
  localparam int BANK_W = (NBANK > 1) ? $clog2(NBANK) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BANK_W-1:0] look_bank,
  input  logic [ROW_W-1:0]  look_row,
  output kind_e             look_kind,
  output logic [NBANK-1:0]  open_mask,
  input  logic              set_en,
  input  logic [BANK_W-1:0] set_bank,
  input  logic [ROW_W-1:0]  set_row,
  input  logic              clr_one,
  input  logic              clr_all,
  input  logic [BANK_W-1:0] clr_bank
);

  logic [ROW_W-1:0] rows [NBANK];

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    logic             vld_r;
    logic [ROW_W-1:0] row_r;
    logic             hit_set;
    logic             hit_clr;

    assign hit_set = set_en && (set_bank == BANK_W'(g));
    assign hit_clr = clr_all || (clr_one && (clr_bank == BANK_W'(g)));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vld_r <= 1'b0;
        row_r <= '0;
      end else if (hit_set) begin
        vld_r <= 1'b1;
        row_r <= set_row;
      end else if (hit_clr) begin
        vld_r <= 1'b0;
      end
    end

    assign open_mask[g] = vld_r;
    assign rows[g]      = row_r;
  end

  always_comb begin
    if (!open_mask[look_bank])             look_kind = K_EMPTY;
    else if (rows[look_bank] == look_row)  look_kind = K_HIT;
    else                                   look_kind = K_MISS;
  end

endmodule

// File: rtl/pgpol_gap_timer.sv
module pgpol_gap_timer
  import pgpol_pkg::*;
#(
  parameter int GAP_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [GAP_W-1:0] load_val,
  output logic             gap_done
);

  logic [GAP_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= GAP_W'(gap_preload(32'(load_val)));
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign gap_done = (cnt_q == '0);

endmodule

// File: rtl/pgpol_leadoff.sv
module pgpol_leadoff
  import pgpol_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic fast,
  output logic due
);

  logic [LEAD_MAX:1] sr_q;
  logic [LEAD_MAX:1] ld;

  always_comb begin
    ld = '0;
    if (start) ld[lead_cycles(fast)] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= (sr_q >> 1) | ld;
  end

  assign due = sr_q[1];

endmodule

// File: rtl/pgpol_evt_cnt.sv
module pgpol_evt_cnt
  import pgpol_pkg::*;
#(
  parameter int NBANK = 4,
  parameter int CNT_W = 16,
  localparam int BANK_W = (NBANK > 1) ? $clog2(NBANK) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ev_en,
  input  logic [BANK_W-1:0]      ev_bank,
  input  kind_e                  ev_kind,
  output logic [NBANK*CNT_W-1:0] hit_flat,
  output logic [NBANK*CNT_W-1:0] miss_flat,
  output logic [NBANK*CNT_W-1:0] empty_flat
);

  for (genvar g = 0; g < NBANK; g++) begin : g_cnt
    logic [CNT_W-1:0] hit_q, miss_q, empty_q;
    logic             mine;

    assign mine = ev_en && (ev_bank == BANK_W'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        hit_q   <= '0;
        miss_q  <= '0;
        empty_q <= '0;
      end else if (mine) begin
        case (ev_kind)
          K_HIT:   hit_q   <= hit_q + 1'b1;
          K_MISS:  miss_q  <= miss_q + 1'b1;
          K_EMPTY: empty_q <= empty_q + 1'b1;
          default: ;
        endcase
      end
    end

    assign hit_flat[g*CNT_W +: CNT_W]   = hit_q;
    assign miss_flat[g*CNT_W +: CNT_W]  = miss_q;
    assign empty_flat[g*CNT_W +: CNT_W] = empty_q;
  end

endmodule

// File: rtl/pgpol_ctrl.sv
module pgpol_ctrl
  import pgpol_pkg::*;
#(
  parameter int NBANK = 4,
  parameter int ROW_W = 13,
  parameter int COL_W = 10,
  parameter int GAP_W = 4,
  parameter int CNT_W = 16,
  localparam int BANK_W = (NBANK > 1) ? $clog2(NBANK) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [BANK_W-1:0]      req_bank,
  input  logic [ROW_W-1:0]       req_row,
  input  logic [COL_W-1:0]       req_col,
  input  logic                   req_write,
  input  logic                   close_all,
  input  logic                   fast_leadoff,
  input  logic [GAP_W-1:0]       t_rp,
  input  logic [GAP_W-1:0]       t_rcd,
  output logic                   cmd_valid,
  output logic [2:0]             cmd_op,
  output logic [BANK_W-1:0]      cmd_bank,
  output logic [ROW_W-1:0]       cmd_row,
  output logic [COL_W-1:0]       cmd_col,
  output logic                   rd_due,
  output logic [NBANK*CNT_W-1:0] hit_cnt,
  output logic [NBANK*CNT_W-1:0] miss_cnt,
  output logic [NBANK*CNT_W-1:0] empty_cnt
);

  // ---- state and latched request ----
  st_e               st_q, st_d;
  logic [BANK_W-1:0] rq_bank;
  logic [ROW_W-1:0]  rq_row;
  logic [COL_W-1:0]  rq_col;
  logic              rq_wr;
  logic              rq_all;

  // ---- named internal events ----
  logic              acc_fire;
  kind_e             acc_kind;
  logic              gap_done;
  logic              issue_pre;
  logic              issue_act;
  logic              issue_rw;
  logic [NBANK-1:0]  open_mask;
  op_e               op_now;

  assign req_ready = (st_q == S_IDLE);
  assign acc_fire  = req_valid && req_ready;

  assign issue_pre = (st_q == S_PRE) && gap_done;
  assign issue_act = (st_q == S_ACT) && gap_done;
  assign issue_rw  = (st_q == S_RW)  && gap_done;

  pgpol_bank_table #(.NBANK(NBANK), .ROW_W(ROW_W)) table_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .look_bank (req_bank),
    .look_row  (req_row),
    .look_kind (acc_kind),
    .open_mask (open_mask),
    .set_en    (issue_act),
    .set_bank  (rq_bank),
    .set_row   (rq_row),
    .clr_one   (issue_pre && !rq_all),
    .clr_all   (issue_pre && rq_all),
    .clr_bank  (rq_bank)
  );

  pgpol_gap_timer #(.GAP_W(GAP_W)) timer_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (issue_pre || issue_act),
    .load_val (issue_pre ? t_rp : t_rcd),
    .gap_done (gap_done)
  );

  pgpol_leadoff lead_i (
    .clk   (clk),
    .rst_n (rst_n),
    .start (issue_rw && !rq_wr),
    .fast  (fast_leadoff),
    .due   (rd_due)
  );

  pgpol_evt_cnt #(.NBANK(NBANK), .CNT_W(CNT_W)) evt_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .ev_en      (acc_fire),
    .ev_bank    (req_bank),
    .ev_kind    (acc_kind),
    .hit_flat   (hit_cnt),
    .miss_flat  (miss_cnt),
    .empty_flat (empty_cnt)
  );

  // ---- sequencing ----
  always_comb begin
    st_d = st_q;
    case (st_q)
      S_IDLE: if (acc_fire) begin
        case (acc_kind)
          K_HIT:   st_d = S_RW;
          K_EMPTY: st_d = S_ACT;
          default: st_d = S_PRE;
        endcase
      end
      S_PRE:   if (issue_pre) st_d = S_ACT;
      S_ACT:   if (issue_act) st_d = S_RW;
      S_RW:    if (issue_rw)  st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      rq_bank <= '0;
      rq_row  <= '0;
      rq_col  <= '0;
      rq_wr   <= 1'b0;
      rq_all  <= 1'b0;
    end else begin
      st_q <= st_d;
      if (acc_fire) begin
        rq_bank <= req_bank;
        rq_row  <= req_row;
        rq_col  <= req_col;
        rq_wr   <= req_write;
        rq_all  <= close_all;
      end
    end
  end

  // ---- command bus ----
  always_comb begin
    op_now = OP_NOP;
    if (issue_pre)      op_now = rq_all ? OP_PREA : OP_PRE;
    else if (issue_act) op_now = OP_ACT;
    else if (issue_rw)  op_now = rq_wr ? OP_WR : OP_RD;
  end

  assign cmd_valid = issue_pre || issue_act || issue_rw;
  assign cmd_op    = op_now;
  assign cmd_bank  = rq_bank;
  assign cmd_row   = rq_row;
  assign cmd_col   = rq_col;

endmodule

// File: rtl/pgpol_chk.sv
module pgpol_chk
  import pgpol_pkg::*;
#(
  parameter int NBANK = 4,
  localparam int BANK_W = (NBANK > 1) ? $clog2(NBANK) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              cmd_valid,
  input logic [2:0]        cmd_op,
  input logic [BANK_W-1:0] cmd_bank,
  input logic              fast_leadoff,
  input logic              rd_due,
  input logic [NBANK-1:0]  open_mask
);

  // column commands only reach a bank with an open row
  p_col_open_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && (cmd_op == OP_RD || cmd_op == OP_WR)) |-> open_mask[cmd_bank]);

  // activate leaves its bank open
  p_act_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_ACT) |=> open_mask[$past(cmd_bank)]);

  // single-bank close touches only that bank
  p_pre_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_PRE) |=>
      (open_mask == ($past(open_mask) & ~(NBANK'(1) << $past(cmd_bank)))));

  // close-all empties every bank at once
  p_prea_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_PREA) |=> (open_mask == '0));

  // open rows change only as a result of a command
  p_mask_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(open_mask) |-> $past(cmd_valid));

  // no acceptance while a sequence runs
  p_busy_cmd_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> !req_ready);

  p_busy_acc_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // leadoff timing
  p_lead_slow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_RD && !fast_leadoff) |-> ##4 rd_due);

  p_lead_fast_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_RD && fast_leadoff) |-> ##3 rd_due);

endmodule

bind pgpol_ctrl pgpol_chk #(.NBANK(NBANK)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .cmd_valid    (cmd_valid),
  .cmd_op       (cmd_op),
  .cmd_bank     (cmd_bank),
  .fast_leadoff (fast_leadoff),
  .rd_due       (rd_due),
  .open_mask    (open_mask)
);

// File: tb/pgpol_ctrl_tb.sv
module pgpol_ctrl_tb_top;

  localparam int NB = 4;
  localparam int RW = 13;
  localparam int CW = 10;
  localparam int GW = 4;
  localparam int CN = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [1:0]    req_bank = '0;
  logic [RW-1:0] req_row = '0;
  logic [CW-1:0] req_col = '0;
  logic          req_write = 1'b0;
  logic          close_all = 1'b0;
  logic          fast_leadoff = 1'b0;
  logic [GW-1:0] t_rp = 4'd2;
  logic [GW-1:0] t_rcd = 4'd3;
  logic          cmd_valid;
  logic [2:0]    cmd_op;
  logic [1:0]    cmd_bank;
  logic [RW-1:0] cmd_row;
  logic [CW-1:0] cmd_col;
  logic          rd_due;
  logic [NB*CN-1:0] hit_cnt, miss_cnt, empty_cnt;

  pgpol_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
    .req_write(req_write), .close_all(close_all), .fast_leadoff(fast_leadoff),
    .t_rp(t_rp), .t_rcd(t_rcd), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_bank(cmd_bank), .cmd_row(cmd_row), .cmd_col(cmd_col),
    .rd_due(rd_due), .hit_cnt(hit_cnt), .miss_cnt(miss_cnt),
    .empty_cnt(empty_cnt)
  );

  always #5 clk = ~clk;

  int total = 0;
  int bad = 0;

  // per-access log, cycle index k counted from acceptance
  int lg_k  [4];
  int lg_op [4];
  int lg_bk [4];
  int lg_row[4];
  int lg_col[4];
  int ncmd;
  int due_k;
  int rdy_k;

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int cnt_of(input logic [NB*CN-1:0] v, input int b);
    return int'(v[b*CN +: CN]);
  endfunction

  task automatic access(input int b, input int r, input int c, input logic wr);
    ncmd = 0; due_k = 0; rdy_k = 0;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_bank = 2'(b); req_row = RW'(r);
    req_col = CW'(c); req_write = wr;
    for (int k = 1; k <= 16; k++) begin
      @(negedge clk);
      if (k == 1) req_valid = 1'b0;
      if (cmd_valid && ncmd < 4) begin
        lg_k[ncmd] = k; lg_op[ncmd] = int'(cmd_op); lg_bk[ncmd] = int'(cmd_bank);
        lg_row[ncmd] = int'(cmd_row); lg_col[ncmd] = int'(cmd_col);
        ncmd++;
      end
      if (rd_due && due_k == 0) due_k = k;
      if (req_ready && rdy_k == 0) rdy_k = k;
    end
  endtask

  task automatic t_reset();
    chk("R1 ready", int'(req_ready), 1);
    chk("R1 cmd_valid", int'(cmd_valid), 0);
    chk("R1 rd_due", int'(rd_due), 0);
    chk("R1 counters", int'(|{hit_cnt, miss_cnt, empty_cnt}), 0);
  endtask

  task automatic t_empty();
    access(0, 5, 7, 1'b0);
    chk("R3 ncmd", ncmd, 2);
    chk("R3 act op", lg_op[0], 1);
    chk("R3 act k", lg_k[0], 1);
    chk("R3 act row", lg_row[0], 5);
    chk("R3 rd op", lg_op[1], 4);
    chk("R3 rd k", lg_k[1], 4);
    chk("R3 rd col", lg_col[1], 7);
    chk("R6 ready back", rdy_k, 5);
    chk("R7 slow due", due_k, 8);
    chk("R8 empty b0", cnt_of(empty_cnt, 0), 1);
  endtask

  task automatic t_hit();
    access(0, 5, 9, 1'b1);
    chk("R2 ncmd", ncmd, 1);
    chk("R2 wr op", lg_op[0], 5);
    chk("R2 wr k", lg_k[0], 1);
    chk("R2 wr col", lg_col[0], 9);
    chk("R6 ready back hit", rdy_k, 2);
    chk("R7 write no due", due_k, 0);
    chk("R8 hit b0", cnt_of(hit_cnt, 0), 1);
  endtask

  task automatic t_miss_single();
    access(1, 3, 1, 1'b0);
    access(0, 9, 2, 1'b0);
    chk("R4 ncmd", ncmd, 3);
    chk("R4 pre op", lg_op[0], 2);
    chk("R4 pre k", lg_k[0], 1);
    chk("R4 pre bank", lg_bk[0], 0);
    chk("R4 act k", lg_k[1], 3);
    chk("R4 act row", lg_row[1], 9);
    chk("R4 rd k", lg_k[2], 6);
    chk("R4 ready back", rdy_k, 7);
    chk("R8 miss b0", cnt_of(miss_cnt, 0), 1);
    access(1, 3, 4, 1'b0);
    chk("R4 other bank hit ncmd", ncmd, 1);
    chk("R4 other bank hit op", lg_op[0], 4);
  endtask

  task automatic t_miss_all();
    close_all = 1'b1;
    access(2, 1, 0, 1'b1);
    access(0, 12, 3, 1'b0);
    chk("R5 ncmd", ncmd, 3);
    chk("R5 prea op", lg_op[0], 3);
    chk("R5 act k", lg_k[1], 3);
    chk("R5 rd k", lg_k[2], 6);
    access(1, 3, 0, 1'b0);
    chk("R5 b1 empty ncmd", ncmd, 2);
    chk("R5 b1 act op", lg_op[0], 1);
    access(2, 1, 0, 1'b0);
    chk("R5 b2 act op", lg_op[0], 1);
    close_all = 1'b0;
  endtask

  task automatic t_fast();
    fast_leadoff = 1'b1;
    access(1, 3, 6, 1'b0);
    chk("R7 fast rd k", lg_k[0], 1);
    chk("R7 fast due", due_k, 4);
    fast_leadoff = 1'b0;
  endtask

  task automatic t_zero_gap();
    t_rp = '0; t_rcd = '0;
    access(1, 8, 0, 1'b0);
    chk("R4 zero-gap pre k", lg_k[0], 1);
    chk("R4 zero-gap act k", lg_k[1], 2);
    chk("R3 zero-gap rd k", lg_k[2], 3);
    t_rp = 4'd2; t_rcd = 4'd3;
  endtask

  task automatic t_counts();
    chk("R8 b0 hit", cnt_of(hit_cnt, 0), 1);
    chk("R8 b0 miss", cnt_of(miss_cnt, 0), 2);
    chk("R8 b0 empty", cnt_of(empty_cnt, 0), 1);
    chk("R8 b1 hit", cnt_of(hit_cnt, 1), 2);
    chk("R8 b1 miss", cnt_of(miss_cnt, 1), 1);
    chk("R8 b1 empty", cnt_of(empty_cnt, 1), 2);
    chk("R8 b2 empty", cnt_of(empty_cnt, 2), 2);
    chk("R8 b3 all", cnt_of(hit_cnt, 3) + cnt_of(miss_cnt, 3) + cnt_of(empty_cnt, 3), 0);
  endtask

  initial begin : wdog
    repeat (20000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_empty();
    t_hit();
    t_miss_single();
    t_miss_all();
    t_fast();
    t_zero_gap();
    t_counts();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule